// File: doc/BRIEF.md
# NAND ECC Sector Status and Erased-Page Checker

This block runs once a full page has been read from NAND flash with hardware ECC decoding switched on. From the page number and the buffer-slot mask it works out which page-buffer slot holds the data, and from that which ECC sectors belong to the page. It then walks those sectors in rising order. For each one it reads a 4-bit error count from a small array of packed 32-bit status words, and it adds up the bits that were corrected.

When a sector reports an uncorrectable result, the block stops walking sectors and scans the page-buffer slot instead. It looks at the whole main area, then at every spare-area byte listed in a programmable ECC-position table. This tells it whether the page is simply erased. An erased page shows up as uncorrectable, because its ECC bytes are all ones, and it must not be reported as an error. When the range of sectors would need a status word beyond the array, the block reports an I/O error and reads no status at all.

The driver loads the position table, pulses a start, and waits for the one-cycle completion strobe. It then reads the corrected total and the three verdict flags, which hold until the next start.

Top module: `ecc_page_checker`

## Requirements
- R1: On an accepted start the slot number is `page_i & buf_mask_i`. The first sector is the slot number times `spp_i` (valid range 1..16), and the sectors first..first+`spp_i`-1 are the ones examined.
- R2: The count for sector n sits in status word n/4, in bits [(3 - n mod 4)*8 + 3 : (3 - n mod 4)*8]. The other nibbles of the word are ignored.
- R3: Sectors are read in increasing order. Every count other than 15 is added to `corr_cnt_o`. A count of 15 ends the walk, and the counts of later sectors are not added.
- R4: If the last sector divided by 4 is 8 or more, `io_err_o` is set and no status word is read (`stat_rd_o` stays low). The corrected count and both verdict flags stay 0, and `done_o` comes one cycle after the start edge.
- R5: `done_o` is high for exactly one cycle. When no sector is uncorrectable it comes `spp_i`+1 cycles after the start edge.
- R6: The main area is `spp_i`*128 words, beginning at word `slot*2*spp_i*128`. Any word in it that is not 0xFFFFFFFF makes the page not blank. The scan stops issuing reads at the first failing word.
- R7: For each table entry k below `pos_cnt_i`, the byte at byte address (slot base + page size + entry k) must be 0xFF. Byte b of the buffer is bits [8*(b mod 4)+7 : 8*(b mod 4)] of word b/4.
- R8: After an uncorrectable sector, either `blank_o` is set (the page is erased) or `uncorr_o` is set, never both. Without an uncorrectable sector both flags are 0 and the page buffer is not read.
- R9: An accepted start clears the corrected count and all flags. After `done_o` the results hold until the next start.
- R10: Spare bytes that are not listed among the first `pos_cnt_i` table entries, and words outside the slot's main area, do not affect the blank verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| page_i | input | 16 | Page number of the completed read |
| buf_mask_i | input | 4 | Buffer-slot mask |
| spp_i | input | 5 | ECC sectors per page (1..16) |
| stat_rd_o | output | 1 | Status word is being read this cycle |
| stat_idx_o | output | 3 | Status word index |
| stat_word_i | input | 32 | Status word at `stat_idx_o` (same cycle) |
| pos_we_i | input | 1 | Position table write enable |
| pos_wa_i | input | 8 | Position table write index |
| pos_wd_i | input | 13 | Spare-area byte offset to store |
| pos_cnt_i | input | 9 | Number of valid table entries (0..256) |
| buf_rd_o | output | 1 | Page buffer read strobe |
| buf_addr_o | output | 16 | Page buffer word address |
| buf_rdata_i | input | 32 | Page buffer data, one cycle after the strobe |
| done_o | output | 1 | One-cycle completion strobe |
| corr_cnt_o | output | 8 | Total corrected bits |
| uncorr_o | output | 1 | Uncorrectable, page not erased |
| blank_o | output | 1 | Uncorrectable sector on an erased page |
| io_err_o | output | 1 | Sector range beyond the status array |

## Verification
The start is sampled at edge 0. The I/O-error verdict is due at edge 1, and a walk without an uncorrectable sector finishes at edge `spp_i`+1. The bench counts falling edges from the start edge and expects `done_o` at exactly that index. Results after a blank scan depend on how far the scan gets, so the bench waits for the strobe within a bound and then checks the flags and the number of page-buffer reads. Every sample is taken at a falling edge. The cycle after the strobe is checked for a dropped `done_o` with the results unchanged, and the first cycle after the start edge is checked for cleared outputs.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RANGE,
    ST_SECT,
    ST_BLANK,
    ST_FIN
  } chk_state_e;

  localparam logic [3:0] CNT_UNCORR = 4'hF;

  // lowest sector of a word lives in the top byte
  function automatic logic [3:0] sect_field(input logic [31:0] w, input logic [1:0] slot);
    case (slot)
      2'd0:    return w[27:24];
      2'd1:    return w[19:16];
      2'd2:    return w[11:8];
      default: return w[3:0];
    endcase
  endfunction

endpackage

// File: rtl/ecc_range_calc.sv
module ecc_range_calc #(
  parameter int BUF_W      = 4,
  parameter int SPP_W      = 5,
  parameter int SEC_W      = 9,
  parameter int STAT_WORDS = 8,
  parameter int SECT_WORDS = 128,
  parameter int IDX_W      = 12,
  parameter int WORD_AW    = 16,
  localparam int BYTE_AW   = WORD_AW + 2
) (
  input  logic [BUF_W-1:0]   bufnum_i,
  input  logic [SPP_W-1:0]   spp_i,
  output logic [SEC_W-1:0]   first_o,
  output logic [SEC_W-1:0]   last_o,
  output logic               io_err_o,
  output logic [IDX_W-1:0]   main_words_o,
  output logic [WORD_AW-1:0] slot_word_o,
  output logic [BYTE_AW-1:0] spare_byte_o
);

  assign first_o      = SEC_W'(bufnum_i) * SEC_W'(spp_i);
  assign last_o       = first_o + SEC_W'(spp_i) - SEC_W'(1);
  assign io_err_o     = 32'(last_o) >= 32'(4 * STAT_WORDS);
  assign main_words_o = IDX_W'(spp_i) * IDX_W'(SECT_WORDS);
  assign slot_word_o  = WORD_AW'(bufnum_i) * WORD_AW'(main_words_o) * WORD_AW'(2);
  assign spare_byte_o = {slot_word_o + WORD_AW'(main_words_o), 2'b00};

endmodule

// File: rtl/ecc_pos_table.sv
module ecc_pos_table #(
  parameter int DEPTH = 256,
  parameter int DW    = 13,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
  end

  assign rd_o = mem_q[ra_i];

endmodule

// File: rtl/ecc_blank_scan.sv
module ecc_blank_scan #(
  parameter int WORD_AW = 16,
  parameter int IDX_W   = 12,
  parameter int POS_AW  = 8,
  parameter int POS_W   = 13,
  localparam int BYTE_AW = WORD_AW + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [WORD_AW-1:0] slot_word_i,
  input  logic [IDX_W-1:0]   main_words_i,
  input  logic [BYTE_AW-1:0] spare_byte_i,
  input  logic [IDX_W-1:0]   pos_cnt_i,
  output logic [POS_AW-1:0]  pos_idx_o,
  input  logic [POS_W-1:0]   pos_val_i,
  output logic               rd_o,
  output logic [WORD_AW-1:0] addr_o,
  input  logic [31:0]        rdata_i,
  output logic               done_o,
  output logic               blank_o
);

  logic               active_q, ecc_ph_q, pend_q, full_q, done_q, blank_q;
  logic [1:0]         lane_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BYTE_AW-1:0] byte_addr;
  logic [7:0]         lane_byte;
  logic               more, mismatch;

  assign pos_idx_o = idx_q[POS_AW-1:0];
  assign byte_addr = spare_byte_i + BYTE_AW'(pos_val_i);
  assign more      = ecc_ph_q ? (idx_q < pos_cnt_i) : (idx_q < main_words_i);

  always_comb begin
    case (lane_q)
      2'd0:    lane_byte = rdata_i[7:0];
      2'd1:    lane_byte = rdata_i[15:8];
      2'd2:    lane_byte = rdata_i[23:16];
      default: lane_byte = rdata_i[31:24];
    endcase
  end

  assign mismatch = pend_q && (full_q ? (rdata_i != 32'hFFFF_FFFF) : (lane_byte != 8'hFF));
  assign rd_o     = active_q && more && !mismatch;
  assign addr_o   = ecc_ph_q ? byte_addr[BYTE_AW-1:2] : slot_word_i + WORD_AW'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ecc_ph_q <= 1'b0;
      pend_q   <= 1'b0;
      full_q   <= 1'b0;
      done_q   <= 1'b0;
      blank_q  <= 1'b0;
      lane_q   <= '0;
      idx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        ecc_ph_q <= 1'b0;
        idx_q    <= '0;
        pend_q   <= 1'b0;
        blank_q  <= 1'b0;
      end else if (active_q) begin
        pend_q <= rd_o;
        full_q <= !ecc_ph_q;
        lane_q <= byte_addr[1:0];
        if (mismatch) begin
          active_q <= 1'b0;
          pend_q   <= 1'b0;
          done_q   <= 1'b1;
          blank_q  <= 1'b0;
        end else if (rd_o) begin
          if (!ecc_ph_q && idx_q == main_words_i - IDX_W'(1)) begin
            ecc_ph_q <= 1'b1;
            idx_q    <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end else if (!pend_q) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          blank_q  <= 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign blank_o = blank_q;

endmodule

// File: rtl/ecc_page_checker.sv
module ecc_page_checker
  import ecc_chk_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int BUF_W      = 4,
  parameter int MAX_SPP    = 16,
  parameter int SECT_BYTES = 512,
  parameter int STAT_WORDS = 8,
  parameter int POS_DEPTH  = 256,
  localparam int SECT_WORDS = SECT_BYTES / 4,
  localparam int SPP_W      = $clog2(MAX_SPP + 1),
  localparam int SEC_W      = BUF_W + SPP_W,
  localparam int STAT_AW    = $clog2(STAT_WORDS),
  localparam int POS_AW     = $clog2(POS_DEPTH),
  localparam int PCNT_W     = $clog2(POS_DEPTH + 1),
  localparam int POS_W      = $clog2(MAX_SPP * SECT_BYTES),
  localparam int BYTE_AW    = BUF_W + 1 + POS_W,
  localparam int WORD_AW    = BYTE_AW - 2,
  localparam int MAIN_W     = $clog2(MAX_SPP * SECT_WORDS + 1),
  localparam int IDX_W      = (MAIN_W > PCNT_W) ? MAIN_W : PCNT_W,
  localparam int CNT_W      = $clog2(14 * MAX_SPP + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [BUF_W-1:0]   buf_mask_i,
  input  logic [SPP_W-1:0]   spp_i,
  output logic               stat_rd_o,
  output logic [STAT_AW-1:0] stat_idx_o,
  input  logic [31:0]        stat_word_i,
  input  logic               pos_we_i,
  input  logic [POS_AW-1:0]  pos_wa_i,
  input  logic [POS_W-1:0]   pos_wd_i,
  input  logic [PCNT_W-1:0]  pos_cnt_i,
  output logic               buf_rd_o,
  output logic [WORD_AW-1:0] buf_addr_o,
  input  logic [31:0]        buf_rdata_i,
  output logic               done_o,
  output logic [CNT_W-1:0]   corr_cnt_o,
  output logic               uncorr_o,
  output logic               blank_o,
  output logic               io_err_o
);

  chk_state_e         state_q;
  logic [BUF_W-1:0]   bufnum_q;
  logic [SPP_W-1:0]   spp_q;
  logic [SEC_W-1:0]   sec_q, last_q;
  logic [CNT_W-1:0]   corr_q;
  logic               uncorr_q, blank_q, ioerr_q, go_q;

  logic [SEC_W-1:0]   rng_first, rng_last;
  logic               rng_ioerr;
  logic [IDX_W-1:0]   main_words;
  logic [WORD_AW-1:0] slot_word;
  logic [BYTE_AW-1:0] spare_byte;
  logic [POS_AW-1:0]  pos_idx;
  logic [POS_W-1:0]   pos_val;
  logic               scan_done, scan_blank;
  logic [3:0]         field;
  logic [PAGE_W-1:0]  page_masked;

  assign page_masked = page_i & PAGE_W'(buf_mask_i);

  ecc_range_calc #(
    .BUF_W(BUF_W), .SPP_W(SPP_W), .SEC_W(SEC_W), .STAT_WORDS(STAT_WORDS),
    .SECT_WORDS(SECT_WORDS), .IDX_W(IDX_W), .WORD_AW(WORD_AW)
  ) u_range (
    .bufnum_i     (bufnum_q),
    .spp_i        (spp_q),
    .first_o      (rng_first),
    .last_o       (rng_last),
    .io_err_o     (rng_ioerr),
    .main_words_o (main_words),
    .slot_word_o  (slot_word),
    .spare_byte_o (spare_byte)
  );

  ecc_pos_table #(.DEPTH(POS_DEPTH), .DW(POS_W)) u_pos (
    .clk_i (clk_i),
    .we_i  (pos_we_i),
    .wa_i  (pos_wa_i),
    .wd_i  (pos_wd_i),
    .ra_i  (pos_idx),
    .rd_o  (pos_val)
  );

  ecc_blank_scan #(
    .WORD_AW(WORD_AW), .IDX_W(IDX_W), .POS_AW(POS_AW), .POS_W(POS_W)
  ) u_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go_q),
    .slot_word_i  (slot_word),
    .main_words_i (main_words),
    .spare_byte_i (spare_byte),
    .pos_cnt_i    (IDX_W'(pos_cnt_i)),
    .pos_idx_o    (pos_idx),
    .pos_val_i    (pos_val),
    .rd_o         (buf_rd_o),
    .addr_o       (buf_addr_o),
    .rdata_i      (buf_rdata_i),
    .done_o       (scan_done),
    .blank_o      (scan_blank)
  );

  assign field      = sect_field(stat_word_i, sec_q[1:0]);
  assign stat_rd_o  = (state_q == ST_SECT);
  assign stat_idx_o = sec_q[STAT_AW+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bufnum_q <= '0;
      spp_q    <= '0;
      sec_q    <= '0;
      last_q   <= '0;
      corr_q   <= '0;
      uncorr_q <= 1'b0;
      blank_q  <= 1'b0;
      ioerr_q  <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          bufnum_q <= page_masked[BUF_W-1:0];
          spp_q    <= spp_i;
          corr_q   <= '0;
          uncorr_q <= 1'b0;
          blank_q  <= 1'b0;
          ioerr_q  <= 1'b0;
          state_q  <= ST_RANGE;
        end
        ST_RANGE: begin
          if (rng_ioerr) begin
            ioerr_q <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            sec_q   <= rng_first;
            last_q  <= rng_last;
            state_q <= ST_SECT;
          end
        end
        ST_SECT: begin
          if (field == CNT_UNCORR) begin
            go_q    <= 1'b1;
            state_q <= ST_BLANK;
          end else begin
            corr_q <= corr_q + CNT_W'(field);
            if (sec_q == last_q) state_q <= ST_FIN;
            else                 sec_q   <= sec_q + SEC_W'(1);
          end
        end
        ST_BLANK: if (scan_done) begin
          blank_q  <= scan_blank;
          uncorr_q <= !scan_blank;
          state_q  <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = (state_q == ST_FIN);
  assign corr_cnt_o = corr_q;
  assign uncorr_o   = uncorr_q;
  assign blank_o    = blank_q;
  assign io_err_o   = ioerr_q;

endmodule

// File: rtl/ecc_page_checker_sva.sv
module ecc_page_checker_sva #(
  parameter int CNT_W   = 8,
  parameter int STAT_AW = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               done_o,
  input logic               io_err_o,
  input logic [CNT_W-1:0]   corr_cnt_o,
  input logic               uncorr_o,
  input logic               blank_o,
  input logic               stat_rd_o,
  input logic [STAT_AW-1:0] stat_idx_o
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_IOERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && io_err_o) |-> (corr_cnt_o == '0 && !uncorr_o && !blank_o)); // R4

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uncorr_o && blank_o)); // R8

  AST_SECT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_o && $past(stat_rd_o)) |-> (stat_idx_o >= $past(stat_idx_o))); // R3

  AST_CORR_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (corr_cnt_o >= $past(corr_cnt_o))); // R9

endmodule

bind ecc_page_checker ecc_page_checker_sva #(.CNT_W(CNT_W), .STAT_AW(STAT_AW)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .io_err_o   (io_err_o),
  .corr_cnt_o (corr_cnt_o),
  .uncorr_o   (uncorr_o),
  .blank_o    (blank_o),
  .stat_rd_o  (stat_rd_o),
  .stat_idx_o (stat_idx_o)
);

// File: tb/ecc_page_checker_tb_top.sv
`timescale 1ns/1ps
module ecc_page_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] page = '0;
  logic [3:0]  mask = '0;
  logic [4:0]  spp = 5'd1;
  logic        stat_rd;
  logic [2:0]  stat_idx;
  logic [31:0] stat_word;
  logic        pos_we = 1'b0;
  logic [7:0]  pos_wa = '0;
  logic [12:0] pos_wd = '0;
  logic [8:0]  pos_cnt = '0;
  logic        buf_rd;
  logic [15:0] buf_addr;
  logic [31:0] buf_rdata = '1;
  logic        done;
  logic [7:0]  corr;
  logic        uncorr, blank, io_err;

  logic [31:0] stat_regs [8];
  logic [31:0] mem [int];

  int checks = 0, fails = 0;
  int n_stat = 0, n_buf = 0;
  int lat;
  int s_corr, s_unc, s_blk;

  always #5 clk = ~clk;

  assign stat_word = stat_regs[stat_idx];

  ecc_page_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_i(page), .buf_mask_i(mask),
    .spp_i(spp), .stat_rd_o(stat_rd), .stat_idx_o(stat_idx), .stat_word_i(stat_word),
    .pos_we_i(pos_we), .pos_wa_i(pos_wa), .pos_wd_i(pos_wd), .pos_cnt_i(pos_cnt),
    .buf_rd_o(buf_rd), .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata),
    .done_o(done), .corr_cnt_o(corr), .uncorr_o(uncorr), .blank_o(blank), .io_err_o(io_err)
  );

  function automatic logic [31:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (buf_rd) begin
      buf_rdata <= mem_rd(int'(buf_addr));
      n_buf = n_buf + 1;
    end
    if (stat_rd) n_stat = n_stat + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_pos(input int idx, input int val);
    @(negedge clk);
    pos_we = 1'b1; pos_wa = 8'(idx); pos_wd = 13'(val);
    @(negedge clk);
    pos_we = 1'b0;
  endtask

  // start at edge 0; lat = falling-edge index after edge 0 where done is seen
  task automatic run(input int pg, input int mk, input int sp);
    page = 16'(pg); mask = 4'(mk); spp = 5'(sp);
    @(negedge clk);
    n_stat = 0; n_buf = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s_corr = corr; s_unc = uncorr; s_blk = blank;
    lat = -1;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin lat = i; break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk("R5 done drops after one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset corr", int'(corr), 0);
    chk("R9 reset flags", int'({uncorr, blank, io_err}), 0);
  endtask

  task automatic t_clean();
    stat_regs[0] = 32'h0E0E0E0E;
    stat_regs[1] = 32'hF250A301;
    run(5, 3, 4);
    chk("R5 clean latency", lat, 5);
    chk("R3 clean corrected sum", int'(corr), 6);
    chk("R1 status reads for four sectors", n_stat, 4);
    chk("R8 no flags without uncorrectable", int'({uncorr, blank, io_err}), 0);
    chk("R8 no page buffer reads", n_buf, 0);
  endtask

  task automatic t_field_pos();
    stat_regs[0] = 32'hF7FFFFFF;
    run(0, 0, 1);
    chk("R2 sector 0 field", int'(corr), 7);
    chk("R5 single sector latency", lat, 2);
    stat_regs[0] = 32'hFFFFFFF9;
    run(3, 3, 1);
    chk("R2 sector 3 field", int'(corr), 9);
    chk("R1 slot 3 flags clear", int'({uncorr, blank}), 0);
  endtask

  task automatic t_ioerr();
    for (int w = 4; w < 8; w++) stat_regs[w] = 32'h0;
    run(1, 1, 16);
    chk("R4 last word 7 not an error", int'(io_err), 0);
    chk("R5 sixteen sector latency", lat, 17);
    chk("R1 sixteen status reads", n_stat, 16);
    run(2, 3, 16);
    chk("R4 io error raised", int'(io_err), 1);
    chk("R4 io error latency", lat, 1);
    chk("R4 no status reads", n_stat, 0);
    chk("R4 count and flags zero", int'(corr) + int'(uncorr) + int'(blank), 0);
  endtask

  task automatic t_stop_first();
    mem.delete();
    pos_cnt = 9'd0;
    stat_regs[0] = 32'h030F050F;
    run(0, 0, 4);
    chk("R3 stops at first uncorrectable", int'(corr), 3);
    chk("R3 status reads stop", n_stat, 2);
    chk("R8 erased page blank", int'(blank), 1);
    chk("R8 erased page not uncorr", int'(uncorr), 0);
    chk("R6 full main area scanned", n_buf, 512);
  endtask

  task automatic t_main_area();
    mem.delete();
    pos_cnt = 9'd0;
    stat_regs[0] = 32'h00000F00;
    mem[511] = 32'h0;
    mem[768] = 32'h0;
    run(1, 1, 2);
    chk("R10 words outside main area ignored", int'(blank), 1);
    chk("R6 slot 1 main reads", n_buf, 256);
    mem[767] = 32'hFFFF7FFF;
    run(1, 1, 2);
    chk("R6 last main word dirty", int'(uncorr), 1);
    chk("R8 dirty page not blank", int'(blank), 0);
    mem[512] = 32'h7FFFFFFF;
    run(1, 1, 2);
    chk("R6 early stop on first word", n_buf, 1);
    chk("R6 first word dirty", int'(uncorr), 1);
  endtask

  task automatic t_ecc_pos();
    set_pos(0, 8); set_pos(1, 9); set_pos(2, 10); set_pos(3, 13); set_pos(4, 11);
    stat_regs[0] = 32'h0F000000;
    mem.delete();
    mem[130] = 32'h00FFFFFF;
    pos_cnt = 9'd4;
    run(0, 0, 1);
    chk("R10 unlisted spare byte ignored", int'(blank), 1);
    chk("R7 main plus four position reads", n_buf, 132);
    pos_cnt = 9'd5;
    run(0, 0, 1);
    chk("R7 listed byte lane 3 dirty", int'(uncorr), 1);
    mem.delete();
    mem[131] = 32'hFFFF00FF;
    pos_cnt = 9'd4;
    run(0, 0, 1);
    chk("R7 listed byte lane 1 dirty", int'(uncorr), 1);
    mem[131] = 32'h00FFFFFF;
    run(0, 0, 1);
    chk("R10 byte past table ignored", int'(blank), 1);
  endtask

  task automatic t_clear_hold();
    stat_regs[0] = 32'h0F000000;
    mem.delete();
    mem[5] = 32'h0;
    pos_cnt = 9'd0;
    run(0, 0, 1);
    chk("R8 setup uncorr", int'(uncorr), 1);
    stat_regs[0] = 32'hF2FFFFFF;
    run(0, 0, 1);
    chk("R9 start clears flags", s_unc + s_blk, 0);
    chk("R9 start clears count", s_corr, 0);
    repeat (4) @(negedge clk);
    chk("R9 count holds after done", int'(corr), 2);
    chk("R9 flags hold clear", int'(uncorr), 0);
  endtask

  initial begin
    for (int w = 0; w < 8; w++) stat_regs[w] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_field_pos();
    t_ioerr();
    t_stop_first();
    t_main_area();
    t_ecc_pos();
    t_clear_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule